// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a word-wide memory port and an instruction decoder. Whenever the queue has room for a whole memory word, it starts a fetch on its own, without waiting for the decoder to ask. The returned bytes go into a small first-in first-out store. The decoder takes them one byte per cycle through a valid/ready handshake.

The queue keeps its own 16-bit fetch offset. This offset is added to a 16-bit code segment value shifted left by four bits, which forms the 20-bit byte address of each fetch. A transfer always returns the aligned 16-bit word that holds the addressed byte, with the even byte in bits 7:0. When the fetch offset is odd, only the upper byte is kept, and the next fetch starts at the following even offset.

When control flow changes, a flush input empties the store and loads a new fetch offset. If a transfer is still outstanding at that moment, the request is still carried to completion, but its data is thrown away.

A three-state controller governs the memory side:
- `FS_IDLE` moves to `FS_FETCH` when there is room and no flush.
- `FS_FETCH` returns to `FS_IDLE` on an acknowledge. If a flush arrives without an acknowledge, it moves to `FS_DISCARD`. A flush together with an acknowledge drops the word and returns to `FS_IDLE`.
- `FS_DISCARD` keeps the request raised until the acknowledge, then returns to `FS_IDLE`.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held, `out_valid` and `bus_req` are 0. After reset the fetch offset is 0, and the first request is raised one cycle after reset is released, at address `code_seg*16`.
- R2: While `bus_req` is high, `bus_addr` equals `(code_seg*16 + offset) mod 2^20`, using the offset of the current fetch. It stays unchanged and `bus_req` stays high until `bus_ack` is seen.
- R3: The queue never holds more than 6 bytes (parameter DEPTH). A new request is raised only when at most 4 bytes are held.
- R4: Bytes leave the queue in the order of increasing fetch offset. Each byte equals the memory byte at its own address.
- R5: An even fetch address stores bits 7:0 and then bits 15:8 of the returned word, and the offset advances by 2. An odd fetch address stores only bits 15:8, and the offset advances by 1. Filling from an odd offset with no reads therefore stops at 5 bytes.
- R6: A flush empties the queue by the next cycle and loads the fetch offset from `flush_ofs`. A request in flight keeps its address until it is acknowledged, and its data is never queued.
- R7: `out_valid` is 1 exactly when the queue holds at least one byte. A byte is removed on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_byte` holds steady.
- R8: The fetch offset wraps from 0xFFFF to 0x0000 within the segment. The fetch after the wrap is at address `code_seg*16`.
- R9: With the decoder stalled and every request acknowledged, the queue keeps fetching ahead until it is full: 6 bytes from an even offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_seg | input | 16 | Code segment value |
| flush | input | 1 | Discard queued bytes and reload the fetch offset |
| flush_ofs | input | 16 | New fetch offset, taken when `flush` is high |
| bus_req | output | 1 | Memory word request |
| bus_addr | output | 20 | Byte address of the request |
| bus_ack | input | 1 | Request completes this cycle; `bus_rdata` is valid |
| bus_rdata | input | 16 | Aligned word; the even byte is in bits 7:0 |
| out_valid | output | 1 | A byte is available to the decoder |
| out_byte | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Decoder takes `out_byte` |

## Verification
The queue is filled with the decoder stalled from both an even offset and an odd offset. The stall levels of 6 and 5 bytes separate the full-word path from the single-byte alignment path. A flush is issued while a request is held open, which shows that the stale word is dropped and not queued. Filling across offset 0xFFFF shows that the wrap stays inside the segment. A long random phase then mixes acknowledge delays, read stalls and flushes with new segments. A model tracks the fill level and the next expected byte for each case, so that ordering, capacity and address errors each show up at a different check.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int SEG_W = 16;
    localparam int OFS_W = 16;
    localparam int PA_W  = 20;

    // Memory-side controller states
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FETCH,
        FS_DISCARD
    } fetch_state_t;

    // Physical byte address: segment shifted by four plus the offset, modulo 2^20
    function automatic logic [PA_W-1:0] seg_to_phys(input logic [SEG_W-1:0] seg,
                                                     input logic [OFS_W-1:0] ofs);
        return {seg, 4'h0} + PA_W'(ofs);
    endfunction

endpackage

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
    import pfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic room,
    input  logic bus_ack,
    output logic bus_req,
    output logic launch,
    output logic accept
);

    fetch_state_t state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (!flush && room)
                    state_d = FS_FETCH;
            end
            FS_FETCH: begin
                if (bus_ack)
                    state_d = FS_IDLE;
                else if (flush)
                    state_d = FS_DISCARD;
            end
            FS_DISCARD: begin
                if (bus_ack)
                    state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FS_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        bus_req = 1'b0;
        launch  = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            FS_IDLE:    launch  = !flush && room;
            FS_FETCH: begin
                bus_req = 1'b1;
                accept  = bus_ack && !flush;
            end
            FS_DISCARD: bus_req = 1'b1;
            default: ;
        endcase
    end

    // R2: a raised request is not withdrawn before its acknowledge
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);

    // R6: a request open during a flush never delivers data
    a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && flush) |=> !accept);

endmodule

// File: rtl/pfq_fetch_ptr.sv
module pfq_fetch_ptr
    import pfq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] code_seg,
    input  logic             flush,
    input  logic [OFS_W-1:0] flush_ofs,
    input  logic             launch,
    input  logic             accept,
    input  logic             bus_req,
    input  logic             bus_ack,
    output logic [PA_W-1:0]  bus_addr,
    output logic             odd
);

    logic [OFS_W-1:0] ofs_q;
    logic [PA_W-1:0]  addr_q;

    // Fetch offset: reload on flush, advance by the bytes kept on a completed fetch
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_q <= '0;
        else if (flush)
            ofs_q <= flush_ofs;
        else if (accept)
            ofs_q <= ofs_q + (ofs_q[0] ? OFS_W'(1) : OFS_W'(2));
    end

    // Address captured when a fetch starts, held for the whole transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (launch)
            addr_q <= seg_to_phys(code_seg, ofs_q);
    end

    assign bus_addr = addr_q;
    assign odd      = ofs_q[0];

    // R2: address stable across a waiting request
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> $stable(bus_addr));

    // R6: a flush loads the supplied offset
    a_r6_ofs_load: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ofs_q == $past(flush_ofs)));

    // R8: the offset wraps inside the segment
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush && ofs_q == {OFS_W{1'b1}}) |=> (ofs_q == '0));

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring #(
    parameter int DEPTH = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic [1:0] wr_n,
    input  logic [7:0] wr_b0,
    input  logic [7:0] wr_b1,
    input  logic       pop,
    output logic [7:0] rd_byte,
    output logic       has_data,
    output logic       room
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [7:0]    slot_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q, wr_nx;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_nx = bump(wr_q);

    // Byte storage: one or two slots written per completed fetch
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_n != 2'd0 && wr_q == PW'(i))
                slot_q[i] <= wr_b0;
            else if (wr_n == 2'd2 && wr_nx == PW'(i))
                slot_q[i] <= wr_b1;
        end
    end

    // Pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else begin
            if (pop)
                rd_q <= bump(rd_q);
            if (wr_n == 2'd1)
                wr_q <= wr_nx;
            else if (wr_n == 2'd2)
                wr_q <= bump(wr_nx);
            count_q <= count_q + CW'(wr_n) - CW'(pop);
        end
    end

    assign rd_byte  = slot_q[rd_q];
    assign has_data = (count_q != '0);
    assign room     = (count_q <= ROOM_MAX);

    // R3: fill level never exceeds capacity
    a_r3_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R3: a write always fits in the space reserved when its fetch started
    a_r3_write_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n != 2'd0 && !flush) |-> ((CW + 1)'(count_q) + (CW + 1)'(wr_n) <= (CW + 1)'(DEPTH)));

    // R6: a flush empties the store
    a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !has_data);

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] code_seg,
    input  logic        flush,
    input  logic [15:0] flush_ofs,
    output logic        bus_req,
    output logic [19:0] bus_addr,
    input  logic        bus_ack,
    input  logic [15:0] bus_rdata,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    input  logic        out_ready
);

    logic       room;
    logic       launch;
    logic       accept;
    logic       odd;
    logic       pop;
    logic [1:0] wr_n;
    logic [7:0] wr_b0;

    pfq_fetch_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .room    (room),
        .bus_ack (bus_ack),
        .bus_req (bus_req),
        .launch  (launch),
        .accept  (accept)
    );

    pfq_fetch_ptr u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_seg  (code_seg),
        .flush     (flush),
        .flush_ofs (flush_ofs),
        .launch    (launch),
        .accept    (accept),
        .bus_req   (bus_req),
        .bus_ack   (bus_ack),
        .bus_addr  (bus_addr),
        .odd       (odd)
    );

    // Odd fetch keeps only the upper byte; even fetch keeps both, low first
    always_comb begin
        wr_n  = 2'd0;
        wr_b0 = bus_rdata[7:0];
        if (accept) begin
            if (odd) begin
                wr_n  = 2'd1;
                wr_b0 = bus_rdata[15:8];
            end else begin
                wr_n  = 2'd2;
            end
        end
    end

    assign pop = out_valid && out_ready;

    pfq_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_n     (wr_n),
        .wr_b0    (wr_b0),
        .wr_b1    (bus_rdata[15:8]),
        .pop      (pop),
        .rd_byte  (out_byte),
        .has_data (out_valid),
        .room     (room)
    );

    // R7: a byte that is not taken stays at the output
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_byte)));

endmodule

// File: tb/sim_prefetch_queue.sv
`timescale 1ns/1ps
module sim_prefetch_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] code_seg;
    logic        flush;
    logic [15:0] flush_ofs;
    logic        bus_req;
    logic [19:0] bus_addr;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    int          mcount;
    logic [15:0] fofs;
    logic [15:0] expofs;
    logic [15:0] mseg;
    bit          stale;
    bit          prev_req;

    always #2 clk = ~clk;

    prefetch_queue u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_seg  (code_seg),
        .flush     (flush),
        .flush_ofs (flush_ofs),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_ready (out_ready)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [7:0] mb(input logic [19:0] p);
        return p[7:0] ^ {p[11:8], p[15:12]} ^ {p[19:16], 4'hA};
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    // One cycle: check outputs, drive inputs, update the model, advance to the next falling edge
    task automatic step(input bit ack, input bit rdy, input bit fl,
                        input logic [15:0] fo, input logic [15:0] nseg);
        logic [19:0] a;
        int add;
        chk(out_valid == (mcount != 0), "R7 valid", out_valid, mcount != 0);
        chk(mcount <= 6, "R3 capacity", mcount, 6);
        if (bus_req && !stale)
            chk(bus_addr == phys(mseg, fofs), "R2 address", bus_addr, phys(mseg, fofs));
        if (bus_req && !prev_req && !stale)
            chk(mcount <= 4, "R3 launch room", mcount, 4);
        prev_req  = bus_req;
        a         = bus_addr;
        bus_ack   = ack && bus_req;
        bus_rdata = {mb(a | 20'h1), mb(a & ~20'h1)};
        out_ready = rdy;
        flush     = fl;
        flush_ofs = fo;
        if (fl) code_seg = nseg;
        if (out_valid && rdy) begin
            chk(out_byte == mb(phys(mseg, expofs)), "R4 order", out_byte, mb(phys(mseg, expofs)));
            expofs = expofs + 16'd1;
            mcount--;
        end
        if (bus_req && ack) begin
            if (stale) stale = 1'b0;
            else if (!fl) begin
                add    = a[0] ? 1 : 2;
                mcount += add;
                fofs   = fofs + 16'(add);
            end
        end
        if (fl) begin
            if (bus_req && !ack) stale = 1'b1;
            mcount = 0;
            fofs   = fo;
            expofs = fo;
            mseg   = nseg;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        bit seen;
        void'($urandom(32'd2024));
        rst_n = 1'b0; code_seg = 16'h2000; flush = 1'b0; flush_ofs = '0;
        bus_ack = 1'b0; bus_rdata = '0; out_ready = 1'b0;
        mcount = 0; fofs = '0; expofs = '0; mseg = 16'h2000; stale = 1'b0; prev_req = 1'b0;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(!out_valid, "R1 valid in reset", out_valid, 0);
            chk(!bus_req, "R1 req in reset", bus_req, 0);
        end
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(bus_req, "R1 first request", bus_req, 1);
        chk(bus_addr == 20'h20000, "R1 first address", bus_addr, 20'h20000);

        // R9 / R5: fill from an even offset with the decoder stalled
        step(1'b0, 1'b0, 1'b1, 16'h0100, mseg);
        repeat (20) step(1'b1, 1'b0, 1'b0, 16'h0, mseg);
        chk(mcount == 6, "R9 fills to six", mcount, 6);
        chk(out_valid, "R9 valid when full", out_valid, 1);
        chk(!bus_req, "R3 no request when full", bus_req, 0);
        repeat (6) step(1'b0, 1'b1, 1'b0, 16'h0, mseg);

        // R6: flush while a request waits
        chk(bus_req, "R6 request pending", bus_req, 1);
        held = bus_addr;
        step(1'b0, 1'b0, 1'b1, 16'h0201, mseg);
        chk(!out_valid, "R6 empty after flush", out_valid, 0);
        chk(bus_req && bus_addr == held, "R6 stale address held", bus_addr, held);
        repeat (20) step(1'b1, 1'b0, 1'b0, 16'h0, mseg);
        chk(mcount == 5, "R5 odd fill stops at five", mcount, 5);
        chk(!bus_req, "R5 no request at five", bus_req, 0);
        repeat (5) step(1'b0, 1'b1, 1'b0, 16'h0, mseg);

        // R8: wrap across the top of the segment
        step(1'b1, 1'b0, 1'b1, 16'hFFFF, 16'hF000);
        seen = 1'b0;
        repeat (12) begin
            if (bus_req && !stale && fofs == 16'h0000 && !seen) begin
                seen = 1'b1;
                chk(bus_addr == {mseg, 4'h0}, "R8 wrap address", bus_addr, {mseg, 4'h0});
            end
            step(1'b1, 1'b0, 1'b0, 16'h0, mseg);
        end
        chk(seen, "R8 wrapped fetch seen", seen, 1);
        repeat (8) step(1'b1, 1'b1, 1'b0, 16'h0, mseg);

        // Random mix of acknowledge delays, stalls and flushes
        for (int i = 0; i < 4000; i++) begin
            bit a, r, f;
            logic [15:0] o, s;
            a = ($urandom % 2) == 0;
            r = ($urandom % 5) < 3;
            f = ($urandom % 50) == 0;
            o = 16'($urandom);
            s = (($urandom % 4) == 0) ? 16'($urandom) : mseg;
            step(a, r, f, o, s);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule